// File: doc/BRIEF.md
# SPI Slave Memory Access Port

This block lets an external SPI host read and write a byte-wide internal RAM that has a 16-bit address. The host pulls the active-low select low and clocks in a command byte, then a 16-bit start address, both MSB first. After that it streams any number of data bytes. Each completed byte moves the address on by one. The address wraps from 0xFFFF to 0x0000. The stream ends when the select rises.

The command byte picks the kind of transfer and whether the local processor gets an interrupt. Read transfers send RAM bytes out on the serial output. Write transfers store received bytes. Any other command is a mailbox command: the block latches the command and address into output registers for the processor, ignores the data bytes, and raises the interrupt.

The SPI pins are sampled by a two-stage synchronizer on the block's system clock. The system clock must run many times faster than the serial clock.

Top module: `spi_mem_port`

## Requirements
- R1: Serial timing is SPI mode 0. The input is sampled on rising serial-clock edges: 8 command bits, then 16 address bits, MSB first. Data bytes start at bit 24, MSB first.
- R2: A write command (bit 7 = 1, bit 6 = 0) produces one single-cycle `ramWr` pulse per complete data byte. The bytes go to ADDR, ADDR+1, ... with the received value on `ramWdata`.
- R3: A read command (bit 7 = 1, bit 6 = 1) issues a single-cycle `ramRd` prefetch after the last address bit and after the last bit of every data byte. `ramRdata` is expected one clock after `ramRd`. The MSB of the byte at ADDR appears on `misoOut` after the falling edge that follows the last address bit. Each later falling edge presents the next bit, and successive bytes come from incrementing addresses.
- R4: A command with bit 7 = 0 is a mailbox command and causes no `ramRd` or `ramWr` at all.
- R5: `misoEn` is low during the 24 header bits, for the whole of write and mailbox transfers, and from the fourth clock after `csN` has been sampled high.
- R6: `irqPulse` is a one-cycle pulse issued after `csN` rises, provided the 24-bit header was complete and the command is a mailbox command or has bit 0 = 0. Read and write commands with bit 0 = 1 give no pulse.
- R7: A mailbox command copies its command byte to `mbCmd` and its address to `mbAddr` when the header completes. Read and write commands leave both registers unchanged. Both reset to zero.
- R8: A data byte cut short by deselect is not written. A transfer deselected before the header completes makes no RAM access, no interrupt and no mailbox update.
- R9: `ramRd` and `ramWr` are never high in the same cycle.
- R10: If the last rising serial-clock edge of a byte and the rise of `csN` are sampled in the same cycle, the byte is still written and the interrupt still follows.
- R11: The streaming address wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, idles low |
| mosi | input | 1 | Serial data from host |
| misoOut | output | 1 | Serial data to host |
| misoEn | output | 1 | Output enable for the serial data pad |
| ramAddr | output | 16 | RAM byte address |
| ramRd | output | 1 | RAM read strobe, data due next cycle |
| ramWr | output | 1 | RAM write strobe |
| ramWdata | output | 8 | RAM write data |
| ramRdata | input | 8 | RAM read data |
| mbCmd | output | 8 | Latched mailbox command |
| mbAddr | output | 16 | Latched mailbox address |
| irqPulse | output | 1 | Processor interrupt pulse |

## Verification
Two functions can land in the same system-clock cycle: the write of the final data byte and the deselect that launches the interrupt. The bench provokes this by raising `csN` and the final `sclk` rise in the same instant, so both pass through the synchronizer together. It then requires both the write pulse, with the correct address and data, and exactly one interrupt. Random transfers also mix deselects that fall mid-byte with reads and writes near the top of the address space, to show that partial bytes vanish while the wrap still holds.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int SYNC_DEPTH = 2;

  typedef struct packed {
    logic shiftIn;
    logic loadCmd;
    logic loadAddr;
    logic mbLatch;
    logic wrByte;
    logic rdFetch;
    logic advance;
    logic txStep;
  } dpStrobe_t;
endpackage

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       mosi,
  input  logic [1:0] cmdKind,
  input  logic       cmdQuiet,
  output logic       mosiS,
  output dpStrobe_t  strobe,
  output logic       driveEn,
  output logic       irqPulse
);
  localparam int HDR_BITS = CMD_W + ADDR_W;
  localparam int LAST_BIT = HDR_BITS + DATA_W - 1;
  localparam int CNT_W    = $clog2(LAST_BIT + 1);
  localparam logic [CNT_W-1:0] CMD_END    = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] HDR_END    = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_START = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] BYTE_END   = CNT_W'(LAST_BIT);

  // pin synchronizers, one per SPI input
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] PIN_RST = 3'b001;  // csN idles high
  logic [NPIN-1:0] pinRaw, pinSync;
  assign pinRaw = {mosi, sclk, csN};

  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    logic [SYNC_DEPTH-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= {SYNC_DEPTH{PIN_RST[p]}};
      else       pipe <= {pipe[SYNC_DEPTH-2:0], pinRaw[p]};
    end
    assign pinSync[p] = pipe[SYNC_DEPTH-1];
  end

  logic csS, sclkS;
  assign csS   = pinSync[0];
  assign sclkS = pinSync[1];
  assign mosiS = pinSync[2];

  logic csPrev, sclkPrev;
  logic [CNT_W-1:0] bitCnt;

  logic active, sclkRise, sclkFall, csRise, csFall, inData;
  logic isRd, isWr, isMb, byteEnd;
  assign active   = !csPrev;
  assign sclkRise = active && sclkS && !sclkPrev;
  assign sclkFall = active && !sclkS && sclkPrev;
  assign csRise   = csS && !csPrev;
  assign csFall   = !csS && csPrev;
  assign inData   = bitCnt >= DATA_START;
  assign isRd     = cmdKind == 2'b11;
  assign isWr     = cmdKind == 2'b10;
  assign isMb     = !cmdKind[1];
  assign byteEnd  = sclkRise && (bitCnt == BYTE_END);

  always_comb begin
    strobe          = '0;
    strobe.shiftIn  = sclkRise;
    strobe.loadCmd  = sclkRise && (bitCnt == CMD_END);
    strobe.loadAddr = sclkRise && (bitCnt == HDR_END);
    strobe.mbLatch  = strobe.loadAddr && isMb;
    strobe.advance  = byteEnd && !isMb;
    strobe.wrByte   = byteEnd && isWr;
    strobe.rdFetch  = (strobe.loadAddr || byteEnd) && isRd;
    strobe.txStep   = sclkFall && inData && isRd;
  end

  logic irqWant;
  assign irqWant = (inData || strobe.loadAddr) && (isMb || !cmdQuiet);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
      bitCnt   <= '0;
      driveEn  <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
      irqPulse <= csRise && irqWant;
      if (csRise || csFall)  bitCnt <= '0;
      else if (sclkRise)     bitCnt <= (bitCnt == BYTE_END) ? DATA_START : bitCnt + 1'b1;
      if (csS)               driveEn <= 1'b0;
      else if (strobe.txStep) driveEn <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_mem_dp.sv
module spi_mem_dp
  import spi_mem_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mosiS,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramRd,
  output logic              ramWr,
  output logic [DATA_W-1:0] ramWdata,
  output logic              misoQ,
  output logic [1:0]        cmdKind,
  output logic              cmdQuiet,
  output logic [CMD_W-1:0]  mbCmd,
  output logic [ADDR_W-1:0] mbAddr
);
  localparam int SH_W = ADDR_W - 1;

  logic [SH_W-1:0]   shiftReg;
  logic [CMD_W-1:0]  cmdReg;
  logic [ADDR_W-1:0] curAddr, addrIn, addrNext;
  logic [DATA_W-1:0] byteIn, txShift;
  logic              rdLoad;

  assign addrIn   = {shiftReg, mosiS};
  assign byteIn   = {shiftReg[DATA_W-2:0], mosiS};
  assign addrNext = curAddr + 1'b1;
  assign cmdKind  = cmdReg[CMD_W-1 -: 2];
  assign cmdQuiet = cmdReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      cmdReg   <= '0;
      curAddr  <= '0;
      ramAddr  <= '0;
      ramRd    <= 1'b0;
      ramWr    <= 1'b0;
      ramWdata <= '0;
      rdLoad   <= 1'b0;
      txShift  <= '0;
      misoQ    <= 1'b0;
      mbCmd    <= '0;
      mbAddr   <= '0;
    end else begin
      ramRd  <= strobe.rdFetch;
      ramWr  <= strobe.wrByte;
      rdLoad <= ramRd;
      if (strobe.shiftIn) shiftReg <= addrIn[SH_W-1:0];
      if (strobe.loadCmd) cmdReg <= {shiftReg[CMD_W-2:0], mosiS};
      if (strobe.loadAddr) begin
        curAddr <= addrIn;
        ramAddr <= addrIn;
      end else if (strobe.wrByte) begin
        ramAddr <= curAddr;
      end else if (strobe.rdFetch) begin
        ramAddr <= addrNext;
      end
      if (strobe.advance) curAddr <= addrNext;
      if (strobe.wrByte) ramWdata <= byteIn;
      if (strobe.mbLatch) begin
        mbCmd  <= cmdReg;
        mbAddr <= addrIn;
      end
      if (rdLoad) begin
        txShift <= ramRdata;
      end else if (strobe.txStep) begin
        misoQ   <= txShift[DATA_W-1];
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_mem_port.sv
module spi_mem_port
  import spi_mem_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  output logic              misoOut,
  output logic              misoEn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramRd,
  output logic              ramWr,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [CMD_W-1:0]  mbCmd,
  output logic [ADDR_W-1:0] mbAddr,
  output logic              irqPulse
);
  dpStrobe_t  strobe;
  logic       mosiS;
  logic [1:0] cmdKind;
  logic       cmdQuiet;

  spi_mem_ctrl #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .cmdKind(cmdKind), .cmdQuiet(cmdQuiet), .mosiS(mosiS),
    .strobe(strobe), .driveEn(misoEn), .irqPulse(irqPulse)
  );

  spi_mem_dp #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .mosiS(mosiS), .strobe(strobe),
    .ramRdata(ramRdata), .ramAddr(ramAddr), .ramRd(ramRd), .ramWr(ramWr),
    .ramWdata(ramWdata), .misoQ(misoOut), .cmdKind(cmdKind),
    .cmdQuiet(cmdQuiet), .mbCmd(mbCmd), .mbAddr(mbAddr)
  );
endmodule

// File: rtl/spi_mem_port_chk.sv
module spi_mem_port_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic misoEn,
  input logic ramRd,
  input logic ramWr,
  input logic irqPulse
);
  // R9
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWr |-> !ramRd);

  // R2
  wr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWr |=> !ramWr);

  // R3
  rd_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramRd |=> !ramRd);

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R6
  irq_after_desel_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(csN, 3));

  // R5
  hiz_desel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !misoEn);
endmodule

bind spi_mem_port spi_mem_port_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .misoEn(misoEn),
  .ramRd(ramRd), .ramWr(ramWr), .irqPulse(irqPulse)
);

// File: tb/tb_spi_mem_port.sv
module tb_spi_mem_port;
  localparam int HALF = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, csN, sclk, mosi, misoOut, misoEn, ramRd, ramWr, irqPulse;
  logic [15:0] ramAddr, mbAddr;
  logic [7:0]  ramWdata, ramRdata, mbCmd;

  spi_mem_port dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .misoOut(misoOut), .misoEn(misoEn), .ramAddr(ramAddr), .ramRd(ramRd),
    .ramWr(ramWr), .ramWdata(ramWdata), .ramRdata(ramRdata),
    .mbCmd(mbCmd), .mbAddr(mbAddr), .irqPulse(irqPulse)
  );

  function automatic logic [7:0] romByte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  always @(posedge clk) if (ramRd) ramRdata <= romByte(ramAddr);

  int checks = 0, errors = 0;
  int wrCount, rdCount, irqCount;
  logic [15:0] wrAddr [16];
  logic [7:0]  wrData [16];
  logic [7:0]  txBytes [8];
  logic [7:0]  rxBytes [8];
  logic [7:0]  expMbCmd = '0;
  logic [15:0] expMbAddr = '0;
  bit done = 0;

  always @(negedge clk) begin
    if (ramWr) begin
      if (wrCount < 16) begin
        wrAddr[wrCount] = ramAddr;
        wrData[wrCount] = ramWdata;
      end
      wrCount++;
    end
    if (ramRd) rdCount++;
    if (irqPulse) irqCount++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic bitOf(input logic [7:0] c, input logic [15:0] a, input int i);
    if (i < 8)  return c[7-i];
    if (i < 24) return a[23-i];
    return txBytes[(i-24)/8][7-((i-24)%8)];
  endfunction

  // one transfer plus its checks
  task automatic xfer(input logic [7:0] c, input logic [15:0] a, input int nBytes,
                      input int extra, input int hdrBits, input bit coincide);
    bit isRd = (c[7:6] == 2'b11);
    bit isWr = (c[7:6] == 2'b10);
    bit isMb = !c[7];
    bit hdrOk = (hdrBits >= 24);
    int total = hdrOk ? 24 + 8*nBytes + extra : hdrBits;
    bit enBad = 0;
    int expIrq, expRd, expWr;
    wrCount = 0; rdCount = 0; irqCount = 0;
    for (int k = 0; k < 8; k++) rxBytes[k] = '0;
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < total; i++) begin
      mosi = bitOf(c, a, i);
      waitClk(HALF);
      if (i < 24 && misoEn) enBad = 1;
      if (i >= 24) begin
        if (misoEn != isRd) enBad = 1;
        if ((i-24)/8 < 8) rxBytes[(i-24)/8][7-((i-24)%8)] = misoOut;
      end
      sclk = 1'b1;
      if (coincide && i == total-1) csN = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    waitClk(HALF);
    csN = 1'b1;
    waitClk(14);

    expWr  = (hdrOk && isWr) ? nBytes : 0;
    expRd  = (hdrOk && isRd) ? nBytes + 1 : 0;
    expIrq = (hdrOk && (isMb || !c[0])) ? 1 : 0;
    if (hdrOk && isMb) begin
      expMbCmd = c;
      expMbAddr = a;
    end
    // R2 R4 R8 R10
    chk(wrCount == expWr, "R2/R4/R8/R10 write count", wrCount, expWr);
    for (int k = 0; k < expWr && k < 16; k++) begin
      // R2 R11
      chk(wrAddr[k] == 16'(a + k), "R2/R11 write address", wrAddr[k], 16'(a + k));
      chk(wrData[k] == txBytes[k], "R1/R2 write data", wrData[k], txBytes[k]);
    end
    // R3 R4 R8
    chk(rdCount == expRd, "R3/R4/R8 prefetch count", rdCount, expRd);
    if (isRd && hdrOk)
      for (int k = 0; k < nBytes; k++)
        chk(rxBytes[k] == romByte(16'(a + k)), "R3/R11 read byte", rxBytes[k], romByte(16'(a + k)));
    // R6
    chk(irqCount == expIrq, "R6/R10 interrupt count", irqCount, expIrq);
    // R7
    chk(mbCmd == expMbCmd, "R7 mailbox command", mbCmd, expMbCmd);
    chk(mbAddr == expMbAddr, "R7 mailbox address", mbAddr, expMbAddr);
    // R5
    chk(!enBad, "R5 output enable during transfer", enBad, 0);
    chk(!misoEn, "R5 output enable after deselect", misoEn, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; mosi = 1'b0;
    wrCount = 0; rdCount = 0; irqCount = 0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    // reset state (R5, R7, R9)
    chk(!misoEn && !irqPulse, "R5/R6 reset outputs", {misoEn, irqPulse}, 0);
    chk(!ramWr && !ramRd, "R9 reset strobes", {ramWr, ramRd}, 0);
    chk(mbCmd == 0 && mbAddr == 0, "R7 reset mailbox", {mbCmd, mbAddr}, 0);

    txBytes[0] = 8'h3C; txBytes[1] = 8'hA1; txBytes[2] = 8'h7E; txBytes[3] = 8'h00;
    txBytes[4] = 8'hFF; txBytes[5] = 8'h55; txBytes[6] = 8'h12; txBytes[7] = 8'h9B;
    xfer(8'h80, 16'h1234, 3, 0, 24, 0);   // R2 write with interrupt
    xfer(8'h81, 16'hFFFE, 3, 0, 24, 0);   // R11 wrap, R6 suppressed
    xfer(8'hC0, 16'h0100, 4, 0, 24, 0);   // R3 read with interrupt
    xfer(8'hC1, 16'hFFFF, 2, 0, 24, 0);   // R3 R11 read wrap, quiet
    xfer(8'hC0, 16'h2000, 0, 0, 24, 0);   // R3 header only read
    xfer(8'h3C, 16'hBEEF, 2, 0, 24, 0);   // R4 R7 mailbox ignores data
    xfer(8'hC1, 16'h4444, 1, 0, 24, 0);   // R7 read leaves mailbox
    xfer(8'h80, 16'h0500, 2, 5, 24, 0);   // R8 partial byte dropped
    xfer(8'h42, 16'h9999, 0, 0, 15, 0);   // R8 truncated header
    xfer(8'h80, 16'h0A0A, 1, 0, 24, 1);   // R10 last byte with deselect
    xfer(8'h80, 16'h0B0B, 3, 0, 24, 1);   // R10 again, longer

    void'($urandom(32'h5EED1234));
    for (int t = 0; t < 24; t++) begin
      logic [7:0] c;
      logic [15:0] a;
      int n, ex, sel;
      bit co;
      sel = $urandom_range(0, 4);
      case (sel)
        0: c = 8'hC0;
        1: c = 8'hC1;
        2: c = 8'h80;
        3: c = 8'h81;
        default: c = 8'($urandom_range(0, 127));
      endcase
      if (sel < 4) c[5:1] = 5'($urandom_range(0, 31));
      a  = ($urandom_range(0, 3) == 0) ? 16'(16'hFFFC + $urandom_range(0, 3)) : 16'($urandom);
      n  = $urandom_range(0, 4);
      ex = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 7) : 0;
      co = (ex == 0 && n > 0 && $urandom_range(0, 3) == 0);
      for (int k = 0; k < 8; k++) txBytes[k] = 8'($urandom);
      xfer(c, a, n, ex, 24, co);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule